// File: doc/BRIEF.md
# GPIO Pin Control Register File

This block is a memory-mapped controller for a bank of general-purpose pins (28 by default). A 32-bit register bus with an address, a write enable, write data and combinational read data gives software control of each pin's direction, its output value and a choice between plain GPIO use and an alternate peripheral function. Output values are never written directly. Software writes a mask to a set register or a clear register, and only the bits written as 1 change. Pins that are not touched by a write keep their state, so two agents can drive different pins without a read-modify-write race.

Every pin input passes through a two-flop synchronizer, and the result is read through a level register. For each pin, a mux picks the pad output value and pad output enable. In GPIO mode they come from the block's own output latch and direction bit. In alternate mode they come from the output and enable signals of a peripheral outside the block. The pad drivers and the peripherals are not part of the block, and it has no edge detection or interrupts.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Pin n maps to bit n of every register, pin input, pad output and alternate peripheral signal, for n from 0 to 27.
- R2: A read at offset 0x00 (level) returns the synchronized pin inputs, with 1 meaning high and 0 meaning low. A write there changes nothing.
- R3: The direction register at offset 0x04 reads back what was last written. For a pin in GPIO mode, a direction bit of 1 drives pad_oe high and 0 drives it low.
- R4: Writing a mask to offset 0x08 (set) drives the output latch of every pin whose bit is 1 to 1. Pins whose bit is 0 keep their latch value. In GPIO mode the latch appears on pad_out.
- R5: Writing a mask to offset 0x0C (clear) drives the output latch of every pin whose bit is 1 to 0. Pins whose bit is 0 keep their latch value.
- R6: Reads at offsets 0x08 and 0x0C return 0.
- R7: The alternate register at offset 0x10 reads back what was last written. For each pin whose bit is 1, pad_out and pad_oe come from alt_out and alt_oe. For each pin whose bit is 0, they come from the output latch and the direction bit.
- R8: A change on pin_in first appears in a level read after the second rising clock edge that samples it. After only one edge the old value is still read.
- R9: Bits 31:28 of every read are 0, and those bits of any write are ignored.
- R10: An address that matches no register (including 0x14, 0x1C and misaligned byte addresses) reads 0, and a write to it changes no register.
- R11: Reset clears the direction register, the alternate register and all output latches, so pad_out and pad_oe are 0 and every pin starts as a GPIO input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write enable, active for one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 28 | Input levels from the pads, asynchronous |
| alt_out | input | 28 | Output values from the alternate peripherals |
| alt_oe | input | 28 | Output enables from the alternate peripherals |
| pad_out | output | 28 | Output value to the pad drivers |
| pad_oe | output | 28 | Output enable to the pad drivers |

## Verification
The hardest state to reach from the ports is a mixed bank: some pins in alternate mode and some in GPIO mode, with direction bits and latch values that differ between the two groups. Only then does a wrong mux select show up on pad_out or pad_oe. The bench first sets direction and latch patterns through the set and clear masks. It then selects the alternate function on only the low nibble while driving alternate signals that are the bit-inverse of the GPIO state, so that every pin's source can be told apart. The two-flop latency is checked by reading the level register after one edge and again after two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_SET   = 32'h08;
  localparam int unsigned OFS_CLR   = 32'h0C;
  localparam int unsigned OFS_ALT   = 32'h10;

  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_ALT,
    SEL_NONE
  } reg_sel_e;

  // Map a byte address onto the register it selects.
  function automatic reg_sel_e decode_addr(input logic [31:0] addr);
    reg_sel_e sel;
    case (addr)
      OFS_LEVEL: sel = SEL_LEVEL;
      OFS_DIR:   sel = SEL_DIR;
      OFS_SET:   sel = SEL_SET;
      OFS_CLR:   sel = SEL_CLR;
      OFS_ALT:   sel = SEL_ALT;
      default:   sel = SEL_NONE;
    endcase
    return sel;
  endfunction

  // New latch value after a set mask and a clear mask (at most one is nonzero).
  function automatic logic [31:0] apply_masks(input logic [31:0] cur,
                                              input logic [31:0] set_m,
                                              input logic [31:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // Cycles since reset, saturating at 2, so that the check never looks before reset.
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  assert_level_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt == 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  reg_sel_e            sel,
  input  logic                we,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] alt_q
);

  // Named write events for the assertions.
  logic wr_dir, wr_set, wr_clr, wr_alt;
  assign wr_dir = we && (sel == SEL_DIR);
  assign wr_set = we && (sel == SEL_SET);
  assign wr_clr = we && (sel == SEL_CLR);
  assign wr_alt = we && (sel == SEL_ALT);

  logic [NUM_PINS-1:0] set_mask, clr_mask, out_next;
  assign set_mask = wr_set ? wdata : '0;
  assign clr_mask = wr_clr ? wdata : '0;
  assign out_next = NUM_PINS'(apply_masks(32'(out_q), 32'(set_mask), 32'(clr_mask)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      alt_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_alt) alt_q <= wdata;
      out_q <= out_next;
    end
  end

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wdata)));

  assert_alt_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alt |=> (alt_q == $past(wdata)));

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (((out_q & $past(wdata)) == $past(wdata)) &&
                ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (((out_q & $past(wdata)) == '0) &&
                ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(out_q));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned NUM_PINS = 28
) (
  input  logic [NUM_PINS-1:0] alt_sel,
  input  logic [NUM_PINS-1:0] gpio_out,
  input  logic [NUM_PINS-1:0] gpio_oe,
  input  logic [NUM_PINS-1:0] periph_out,
  input  logic [NUM_PINS-1:0] periph_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pad_out[p] = alt_sel[p] ? periph_out[p] : gpio_out[p];
    assign pad_oe[p]  = alt_sel[p] ? periph_oe[p]  : gpio_oe[p];
  end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 28,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] level_s;
  logic [NUM_PINS-1:0] dir_q, out_q, alt_q;

  assign sel = decode_addr(32'(bus_addr));

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (level_s)
  );

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .we    (bus_we),
    .wdata (bus_wdata[NUM_PINS-1:0]),
    .dir_q (dir_q),
    .out_q (out_q),
    .alt_q (alt_q)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .alt_sel    (alt_q),
    .gpio_out   (out_q),
    .gpio_oe    (dir_q),
    .periph_out (alt_out),
    .periph_oe  (alt_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  logic [NUM_PINS-1:0] rd_bits;
  always_comb begin
    case (sel)
      SEL_LEVEL: rd_bits = level_s;
      SEL_DIR:   rd_bits = dir_q;
      SEL_ALT:   rd_bits = alt_q;
      default:   rd_bits = '0;
    endcase
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rd_bits};

  assert_wo_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == SEL_SET) || (sel == SEL_CLR)) |-> (bus_rdata == '0));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_PINS] == '0);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));

  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_n |-> ((pad_oe == '0) && (pad_out == '0)));

endmodule

// File: tb/tb_gpio_pin_ctrl.sv
module tb_gpio_pin_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] pin_in = '0;
  logic [27:0] alt_out = '0;
  logic [27:0] alt_oe = '0;
  logic [27:0] pad_out, pad_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {write, addr, data, expected read at addr afterwards, expected pad_out}
  localparam logic [104:0] VEC [NV] = '{
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0FFF_FFFF, 32'h0000_0000}, // R3 R9
    {1'b1, 8'h08, 32'h0000_00F0, 32'h0000_0000, 32'h0000_00F0}, // R4 R6
    {1'b1, 8'h08, 32'h0F00_0003, 32'h0000_0000, 32'h0F00_00F3}, // R4 R1
    {1'b1, 8'h0C, 32'h0000_0030, 32'h0000_0000, 32'h0F00_00C3}, // R5
    {1'b1, 8'h0C, 32'h0000_0000, 32'h0000_0000, 32'h0F00_00C3}, // R5 zero mask
    {1'b1, 8'h08, 32'h0000_0000, 32'h0000_0000, 32'h0F00_00C3}, // R4 zero mask
    {1'b1, 8'h0C, 32'hF000_0000, 32'h0000_0000, 32'h0F00_00C3}, // R9
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0F00_00C3}, // R2 level ignores write
    {1'b1, 8'h04, 32'h0000_00FF, 32'h0000_00FF, 32'h0F00_00C3}, // R3
    {1'b1, 8'h0C, 32'h0FFF_FFFF, 32'h0000_0000, 32'h0000_0000}  // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input string tag, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state, checked while reset is held
    chk("R11 pad_out in reset", 32'(pad_out), 32'h0);
    chk("R11 pad_oe in reset", 32'(pad_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read("R11 dir after reset", 5'h04, 32'h0);
    bus_read("R11 alt after reset", 5'h10, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][104]) bus_write(VEC[i][100:96], VEC[i][95:64]);
      bus_read($sformatf("R3/R4/R5/R6 table row %0d rdata", i), VEC[i][100:96], VEC[i][63:32]);
      chk($sformatf("R1/R4/R5 table row %0d pad_out", i), 32'(pad_out), VEC[i][31:0]);
    end
    // R3: dir=0x000000FF, all in GPIO mode
    chk("R3 pad_oe follows dir", 32'(pad_oe), 32'h0000_00FF);

    // R8 / R2: two-edge latency of the level register
    @(negedge clk);
    pin_in = 28'hABC_DEF1;
    bus_addr = 5'h00;
    @(negedge clk);
    bus_read("R8 level after one edge", 5'h00, 32'h0);
    @(negedge clk);
    bus_read("R2 R8 level after two edges", 5'h00, 32'h0ABC_DEF1);
    pin_in = 28'h543_210E;
    repeat (2) @(negedge clk);
    bus_read("R2 level second pattern", 5'h00, 32'h0543_210E);

    // R7: mixed bank. latch = 0x0000_0F00 via set, dir = 0x0000_00FF
    bus_write(5'h08, 32'h0000_0F00);
    alt_out = 28'hFFF_F0FF;   // inverse of latch
    alt_oe  = 28'hFFF_FF00;   // inverse of dir
    bus_write(5'h10, 32'h0000_000F);
    bus_read("R7 alt readback", 5'h10, 32'h0000_000F);
    chk("R7 pad_out mixed", 32'(pad_out), 32'h0000_0F0F);
    chk("R7 pad_oe mixed", 32'(pad_oe), 32'h0000_00F0);
    bus_write(5'h10, 32'h0FFF_FFFF);
    chk("R7 pad_out all alt", 32'(pad_out), 32'h0FFF_F0FF);
    chk("R7 pad_oe all alt", 32'(pad_oe), 32'h0FFF_FF00);
    bus_write(5'h10, 32'h0);
    chk("R7 pad_out back to gpio", 32'(pad_out), 32'h0000_0F00);

    // R10: unmapped and misaligned addresses
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_write(5'h1C, 32'hFFFF_FFFF);
    bus_write(5'h05, 32'h0000_0000);
    bus_write(5'h09, 32'hFFFF_FFFF);
    bus_read("R10 unmapped 0x14 reads 0", 5'h14, 32'h0);
    bus_read("R10 misaligned 0x05 reads 0", 5'h05, 32'h0);
    bus_read("R10 dir unchanged", 5'h04, 32'h0000_00FF);
    bus_read("R10 alt unchanged", 5'h10, 32'h0);
    chk("R10 latch unchanged", 32'(pad_out), 32'h0000_0F00);

    // R11: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 pad_out after reset", 32'(pad_out), 32'h0);
    chk("R11 pad_oe after reset", 32'(pad_oe), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read("R11 dir cleared", 5'h04, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule